// File: doc/BRIEF.md
# Double-Buffered Audio Sample Fetch Queue

This block feeds an audio serial output path with sample data fetched from memory. Software first writes a start byte address and then a byte length; the length write queues the pair. Two pairs can be held at once: one active, one waiting. The active transfer is split into 8-byte read requests on a simple request/acknowledge memory port, and each returned 64-bit word is passed to the downstream sample buffer as a one-cycle pulse.

Software reads the bytes left in the active transfer and a status word. The status word holds a FULL flag (a second pair is waiting), a busy flag (bytes remain), and the engine, request and enable bits. An interrupt is raised when the last 8-byte fetch of a buffer is accepted, so software can queue the next buffer straight away. Any status write clears the interrupt. A bit-rate input of zero acts as a soft flush that empties both slots.

The fetch engine is a three-state machine. In `FS_IDLE` it starts a fetch (transition *start*) when DMA is enabled, bytes remain, no flush is active and the sample buffer is not full. It then latches the address and moves to `FS_ISSUE`. In `FS_ISSUE` it holds the request until the memory acknowledges (transition *accept*) and captures the data. It then moves to `FS_HANDOFF`. In `FS_HANDOFF` it presents the word to the sample buffer for one cycle and returns to `FS_IDLE` (transition *handoff*).

Top module: `audio_dma_queue`

## Requirements
- R1: An address write keeps bits [23:3] of `wr_data` and forces bits [2:0] to zero. Every `mem_addr` presented with `mem_req` therefore has bits [2:0] at zero, and the first fetch of a buffer uses the written address with those bits cleared.
- R2: A length write takes `wr_data[17:0]` with bits [2:0] forced to zero. If no bytes remain and no pair is waiting, the pair becomes active at once, and `len_remaining` shows the length in the next cycle. A length that is zero after masking is ignored.
- R3: A length write while bytes remain loads the waiting slot and sets FULL; a length write while FULL is dropped. The waiting pair becomes active one cycle after the remaining count reaches zero, and FULL then clears.
- R4: Each accepted request fetches 8 bytes at the current address. On acceptance the address advances by 8 and `len_remaining` drops by 8, so fetch addresses run in sequence through the active buffer and then through the waiting buffer.
- R5: Once raised, `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is high.
- R6: No new request starts while `smp_full` is high or DMA is disabled. DMA is enabled by a control write with `wr_data[0]`=1 and is off after reset. Clearing it stops new requests but lets an outstanding one finish, and the remaining length is left as is.
- R7: The word returned with `mem_ack` appears on `smp_data` with `smp_valid` high for exactly one cycle, in the cycle after the acknowledge.
- R8: `irq` rises in the cycle after a request is accepted that brings the remaining count to zero, and not before. Any status write clears it.
- R9: `status_word` has bit 31 = FULL, bit 30 = bytes remain, bit 27 = engine not idle, bit 26 = `mem_req`, bit 25 = DMA enable, bit 0 = FULL. All other bits are zero.
- R10: While `bit_rate` is zero, both slots are emptied (`len_remaining` 0, FULL 0) and length writes are ignored. A request already outstanding still completes, but it changes no count and raises no interrupt.
- R11: After reset, `len_remaining`, `status_word`, `irq`, `mem_req` and `smp_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_rate | input | 4 | Serial bit-rate setting; zero flushes the queue |
| addr_we | input | 1 | Address write strobe |
| len_we | input | 1 | Length write strobe (queues the pair) |
| ctrl_we | input | 1 | Control write strobe (bit 0 = DMA enable) |
| status_we | input | 1 | Status write strobe (clears interrupt) |
| wr_data | input | 24 | Write data for the strobes above |
| len_remaining | output | 18 | Bytes left in the active transfer |
| status_word | output | 32 | Status flags |
| irq | output | 1 | Buffer-finished interrupt |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | 8-byte aligned read address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 64 | Memory read data |
| smp_valid | output | 1 | Sample word valid pulse |
| smp_data | output | 64 | Sample word |
| smp_full | input | 1 | Sample buffer cannot take more data |

## Verification
The fetch path is driven in four patterns. In the first, two buffers are queued back to back with an immediate acknowledge, which shows that the second buffer follows the first with no gap and no lost beat. In the second, the acknowledge is withheld, so a request still waiting can be told apart from one already accepted, both in the remaining count and in the interrupt. In the third, the sample buffer is held full. In the fourth, DMA is disabled while a request is outstanding, which separates "no new request" from "abort the current one". A soft flush is then applied with both slots loaded, and again with a fetch in flight, to show that the flush empties both slots and lets the outstanding fetch finish quietly.

// File: rtl/adq_pkg.sv
package adq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_ISSUE   = 2'd1,
        FS_HANDOFF = 2'd2
    } fetch_state_t;

    localparam int ST_FULL_HI  = 31;
    localparam int ST_BUSY     = 30;
    localparam int ST_ENGINE   = 27;
    localparam int ST_REQ      = 26;
    localparam int ST_ENABLE   = 25;
    localparam int ST_FULL_LO  = 0;
    localparam int STATUS_W    = 32;
endpackage

// File: rtl/adq_slot_queue.sv
module adq_slot_queue #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 18,
    parameter int BEAT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              addr_we,
    input  logic              len_we,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              beat_taken,
    output logic [ADDR_W-1:0] act_addr,
    output logic [LEN_W-1:0]  act_len,
    output logic              pend_full,
    output logic              last_beat
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'(BEAT_BYTES - 1));
    localparam logic [LEN_W-1:0]  STEP_LEN  = (LEN_W)'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR = (ADDR_W)'(BEAT_BYTES);

    logic [ADDR_W-1:0] stage_addr, pend_addr, masked;
    logic [LEN_W-1:0]  pend_len, new_len;
    logic              len_ok;

    assign masked  = wr_data & ALIGN_MASK;
    assign new_len = masked[LEN_W-1:0];
    assign len_ok  = len_we && (new_len != '0) && !flush;
    assign last_beat = beat_taken && (act_len == STEP_LEN) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_addr <= '0;
            pend_addr  <= '0;
            pend_len   <= '0;
            pend_full  <= 1'b0;
            act_addr   <= '0;
            act_len    <= '0;
        end else begin
            if (addr_we)
                stage_addr <= masked;
            if (flush) begin
                act_len   <= '0;
                pend_full <= 1'b0;
            end else if (act_len == '0) begin
                if (pend_full) begin
                    act_addr <= pend_addr;
                    act_len  <= pend_len;
                    if (len_ok) begin
                        pend_addr <= stage_addr;
                        pend_len  <= new_len;
                    end else begin
                        pend_full <= 1'b0;
                    end
                end else if (len_ok) begin
                    act_addr <= stage_addr;
                    act_len  <= new_len;
                end
            end else begin
                if (beat_taken) begin
                    act_len  <= act_len - STEP_LEN;
                    act_addr <= act_addr + STEP_ADDR;
                end
                if (len_ok && !pend_full) begin
                    pend_addr <= stage_addr;
                    pend_len  <= new_len;
                    pend_full <= 1'b1;
                end
            end
        end
    end

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_len < $past(act_len)) && !$past(flush) |-> act_len == $past(act_len) - STEP_LEN); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (act_len == '0) && !pend_full); // R10
    AST_ADDR_ALIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        act_addr[ALIGN_W-1:0] == '0); // R1
endmodule

// File: rtl/adq_fetch_fsm.sv
module adq_fetch_fsm
    import adq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              have_work,
    input  logic              sink_full,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_taken,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              engine_busy
);
    fetch_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE:    if (dma_en && have_work && !sink_full) state_nx = FS_ISSUE;
            FS_ISSUE:   if (mem_ack) state_nx = FS_HANDOFF;
            FS_HANDOFF: state_nx = FS_IDLE;
            default:    state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            smp_data <= '0;
        end else begin
            if (state == FS_IDLE && state_nx == FS_ISSUE)
                mem_addr <= act_addr;
            if (beat_taken)
                smp_data <= mem_rdata;
        end
    end

    always_comb begin
        mem_req     = (state == FS_ISSUE);
        beat_taken  = (state == FS_ISSUE) && mem_ack;
        smp_valid   = (state == FS_HANDOFF);
        engine_busy = (state != FS_IDLE);
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(dma_en) && !$past(sink_full)); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R7
    AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(mem_req && mem_ack)); // R7
endmodule

// File: rtl/audio_dma_queue.sv
module audio_dma_queue
    import adq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 18,
    parameter int DATA_W     = 64,
    parameter int RATE_W     = 4,
    parameter int BEAT_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RATE_W-1:0]   bit_rate,
    input  logic                addr_we,
    input  logic                len_we,
    input  logic                ctrl_we,
    input  logic                status_we,
    input  logic [ADDR_W-1:0]   wr_data,
    output logic [LEN_W-1:0]    len_remaining,
    output logic [STATUS_W-1:0] status_word,
    output logic                irq,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                smp_valid,
    output logic [DATA_W-1:0]   smp_data,
    input  logic                smp_full
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);

    logic              flush, dma_en, beat_taken, last_beat, pend_full, engine_busy;
    logic [ADDR_W-1:0] act_addr;
    logic [LEN_W-1:0]  act_len;

    assign flush = (bit_rate == '0);

    adq_slot_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_slots (
        .clk(clk), .rst_n(rst_n), .flush(flush), .addr_we(addr_we), .len_we(len_we),
        .wr_data(wr_data), .beat_taken(beat_taken), .act_addr(act_addr),
        .act_len(act_len), .pend_full(pend_full), .last_beat(last_beat)
    );

    adq_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
        .have_work((act_len != '0) && !flush), .sink_full(smp_full),
        .act_addr(act_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .beat_taken(beat_taken),
        .smp_valid(smp_valid), .smp_data(smp_data), .engine_busy(engine_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (ctrl_we)
                dma_en <= wr_data[0];
            if (last_beat)
                irq <= 1'b1;
            else if (status_we)
                irq <= 1'b0;
        end
    end

    always_comb begin
        status_word             = '0;
        status_word[ST_FULL_HI] = pend_full;
        status_word[ST_BUSY]    = (act_len != '0);
        status_word[ST_ENGINE]  = engine_busy;
        status_word[ST_REQ]     = mem_req;
        status_word[ST_ENABLE]  = dma_en;
        status_word[ST_FULL_LO] = pend_full;
    end

    assign len_remaining = act_len;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R5
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[ALIGN_W-1:0] == '0); // R1
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_ack)); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        status_we && !(mem_req && mem_ack) |=> !irq); // R8
endmodule

// File: tb/audio_dma_queue_test.sv
module audio_dma_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bit_rate = 4'hF;
    logic        addr_we = 0, len_we = 0, ctrl_we = 0, status_we = 0;
    logic [23:0] wr_data = '0;
    logic [17:0] len_remaining;
    logic [31:0] status_word;
    logic        irq, mem_req, mem_ack, smp_valid, smp_full;
    logic [23:0] mem_addr;
    logic [63:0] mem_rdata, smp_data;

    int total = 0, bad = 0;
    bit ack_on = 1'b1;
    logic [23:0] acc_addr [64];
    logic [63:0] smp_log [64];
    int acc_n = 0, smp_n = 0;

    always #2.5 clk = ~clk;

    audio_dma_queue uut (
        .clk(clk), .rst_n(rst_n), .bit_rate(bit_rate), .addr_we(addr_we), .len_we(len_we),
        .ctrl_we(ctrl_we), .status_we(status_we), .wr_data(wr_data),
        .len_remaining(len_remaining), .status_word(status_word), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_full(smp_full)
    );

    // memory model: acknowledges at the first falling edge it sees a request
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && ack_on) begin
                mem_ack = 1'b1;
                mem_rdata = {8'hA5, 32'h0, mem_addr};
                if (acc_n < 64) acc_addr[acc_n] = mem_addr;
                acc_n++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (smp_valid) begin
                if (smp_n < 64) smp_log[smp_n] = smp_data;
                smp_n++;
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int kind, logic [23:0] d);
        @(negedge clk);
        wr_data = d;
        addr_we = (kind == 0); len_we = (kind == 1);
        ctrl_we = (kind == 2); status_we = (kind == 3);
        @(negedge clk);
        addr_we = 0; len_we = 0; ctrl_we = 0; status_we = 0;
    endtask

    task automatic soft_flush();
        @(negedge clk); bit_rate = 4'h0;
        @(negedge clk); bit_rate = 4'hF;
        wr(3, 0);
    endtask

    task automatic t_reset();
        check("R11 len", len_remaining, 0);
        check("R11 status", status_word, 0);
        check("R11 irq", irq, 0);
        check("R11 req", mem_req, 0);
        check("R11 valid", smp_valid, 0);
    endtask

    task automatic t_queue();
        wr(0, 24'h123457); wr(1, 24'h000013);
        check("R2 len active", len_remaining, 18'h10);
        wr(1, 24'h000005);
        check("R2 zero len ignored", len_remaining, 18'h10);
        check("R2 no full", status_word[31], 0);
        wr(0, 24'h002000); wr(1, 24'd24);
        check("R3 full", {status_word[31], status_word[0]}, 2'b11);
        check("R3 active unchanged", len_remaining, 18'h10);
        wr(0, 24'h009000); wr(1, 24'd8);
        check("R9 status idle queued", status_word, 32'hC000_0001);
        wr(2, 24'h1);
        repeat (60) @(negedge clk);
        check("R3 beats (third dropped)", acc_n, 5);
        check("R1 first addr", acc_addr[0], 24'h123450);
        check("R4 addr 2", acc_addr[1], 24'h123458);
        check("R3 promoted addr", acc_addr[2], 24'h002000);
        check("R4 addr 5", acc_addr[4], 24'h002010);
        check("R7 samples", smp_n, 5);
        for (int i = 0; i < 5; i++)
            check("R7 data", smp_log[i], {8'hA5, 32'h0, acc_addr[i]});
        check("R8 irq set", irq, 1);
        check("R9 status enabled idle", status_word, 32'h0200_0000);
        wr(3, 0);
        check("R8 irq cleared", irq, 0);
    endtask

    task automatic t_hold();
        int n0 = acc_n;
        ack_on = 0;
        wr(0, 24'h000400); wr(1, 24'd8);
        repeat (8) @(negedge clk);
        check("R5 req held", mem_req, 1);
        check("R5 addr held", mem_addr, 24'h000400);
        check("R8 no irq before accept", irq, 0);
        check("R4 no decrement before accept", len_remaining, 8);
        check("R9 status requesting", status_word, 32'h4E00_0000);
        ack_on = 1;
        repeat (10) @(negedge clk);
        check("R8 irq on last", irq, 1);
        check("R4 len zero", len_remaining, 0);
        check("R5 one beat", acc_n - n0, 1);
        wr(3, 0);
    endtask

    task automatic t_stall();
        int n0 = acc_n;
        smp_full = 1;
        wr(0, 24'h000800); wr(1, 24'd8);
        repeat (10) @(negedge clk);
        check("R6 stalled by full", mem_req, 0);
        check("R6 len kept", len_remaining, 8);
        smp_full = 0;
        repeat (10) @(negedge clk);
        check("R6 resumes", acc_n - n0, 1);
        check("R6 done", len_remaining, 0);
        wr(3, 0);
    endtask

    task automatic t_disable();
        int n0 = acc_n, s0 = smp_n;
        ack_on = 0;
        wr(0, 24'h000C00); wr(1, 24'd64);
        repeat (5) @(negedge clk);
        check("R6 requesting", mem_req, 1);
        wr(2, 24'h0);
        ack_on = 1;
        repeat (20) @(negedge clk);
        check("R6 only outstanding finishes", acc_n - n0, 1);
        check("R7 one sample", smp_n - s0, 1);
        check("R6 len frozen", len_remaining, 56);
        check("R6 no req", mem_req, 0);
        soft_flush();
    endtask

    task automatic t_flush();
        int n0;
        wr(0, 24'h001000); wr(1, 24'd32);
        wr(0, 24'h001100); wr(1, 24'd32);
        check("R3 full before flush", status_word[31], 1);
        @(negedge clk); bit_rate = 4'h0;
        len_we = 1; wr_data = 24'd8;
        @(negedge clk); len_we = 0;
        @(negedge clk); bit_rate = 4'h3;
        check("R10 flushed len", len_remaining, 0);
        check("R10 flushed flags", status_word[31:30], 2'b00);
        n0 = acc_n;
        wr(2, 24'h1);
        repeat (20) @(negedge clk);
        check("R10 nothing queued", acc_n - n0, 0);
        ack_on = 0;
        wr(0, 24'h001200); wr(1, 24'd8);
        repeat (4) @(negedge clk);
        check("R10 in flight", mem_req, 1);
        bit_rate = 4'h0;
        ack_on = 1;
        repeat (10) @(negedge clk);
        check("R10 in-flight completes", acc_n - n0, 1);
        check("R10 no irq from flushed", irq, 0);
        check("R10 len stays zero", len_remaining, 0);
        bit_rate = 4'hF;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        smp_full = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_queue();
        t_hold();
        t_stall();
        t_disable();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule